// File: doc/BRIEF.md
# Word-serial Montgomery multiplier

This block computes the Montgomery product T = X·Y·R⁻¹ mod N for moduli of up to several thousand bits. It works one 32-bit word at a time, using the coarsely integrated operand scanning form of the algorithm. The three operands sit in a shared dual-port word RAM, least significant word first. The modulus N and the operand Y each occupy `n_len + 1` words, and the operand X occupies `x_len + 1` words. R is 2^(32·(n_len+1)). The caller places a zero word at the top of N when an overflow digit is needed. With that word present, and with X and Y below 2N, the result also stays below 2N. No final subtraction is made.

Software supplies only the low 8 bits of the reduction constant N' (from N·N' ≡ −1 mod 2^8). At the start of a run the block reads the lowest word of N. It then applies two Newton steps to widen the constant to a full 32-bit word. For each outer iteration it reads one X word. It then makes one multiply-accumulate pass over Y through read port A, and one reduction pass over N through read port B. At the end it writes the `n_len + 1` result words back through port A. One cycle after the last write it raises `done` for a single cycle. It also sets `overflow` when the carry word above the result is non-zero.

Top module: `mont_mul`

## Requirements
- R1: The words written back, together with `overflow` weighted by R, equal exactly (X·Y + m·N)/R, where m = (X·Y·(−N⁻¹)) mod R and R = 2^(32·(n_len+1)). This value is congruent to X·Y·R⁻¹ mod N and is below 2N.
- R2: Exactly `n_len + 1` words are written, least significant first, at consecutive addresses starting at the result base. The words just below and just above that range are not written.
- R3: `overflow` is 0 in the cycle after a start is accepted. It is loaded at completion with 1 when the carry word above the result is non-zero, and otherwise holds its value while the block is idle.
- R4: `busy` is 1 in the cycle after an accepted start and stays 1 until `done`. `done` is high for exactly one cycle, the cycle after the last result write, and `busy` is 0 in the cycle that follows.
- R5: A `start` pulse while `busy` is 1 is ignored. The running computation keeps the configuration it captured at its own start.
- R6: X words at offsets above `x_len`, up to `n_len`, are treated as zero and never read, whatever the RAM holds there.
- R7: Bit 0 of every base address is ignored, so each operand and the result start at the even address at or below the given base.
- R8: Only the 8-bit constant `n_acc` (the low byte of −N⁻¹ mod 2^8) is supplied. The 32-bit quotient constant is derived inside the block from that byte and the lowest word of N.
- R9: After reset, `busy`, `done`, `overflow` and the RAM write enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiplication when idle |
| x_base | input | ADDR_W | Word address of X (bit 0 ignored) |
| y_base | input | ADDR_W | Word address of Y (bit 0 ignored) |
| n_base | input | ADDR_W | Word address of N (bit 0 ignored) |
| r_base | input | ADDR_W | Word address of the result (bit 0 ignored) |
| x_len | input | LEN_W | X word count minus one |
| n_len | input | LEN_W | N and Y word count minus one |
| n_acc | input | ACC_W | Low byte of −N⁻¹ modulo 2^8 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Carry word above the result was non-zero |
| ram_a_addr | output | ADDR_W | Port A address (X, Y reads; result writes) |
| ram_a_we | output | 1 | Port A write enable |
| ram_a_wdata | output | WORD_W | Port A write data |
| ram_a_rdata | input | WORD_W | Port A read data, one cycle after the address |
| ram_b_addr | output | ADDR_W | Port B address (N reads) |
| ram_b_rdata | input | WORD_W | Port B read data, one cycle after the address |

## Verification
The bench builds the block with 32-bit words, 11-bit addresses and `MAX_WORDS` = 8. This keeps the scratch register file at ten words while still covering the 32-, 64- and 128-bit moduli used, each with its zero padding word. The reference is an exact wide-integer form of (X·Y + m·N)/R. That form reaches the overflow corner: with N = 2^64−1 and X = Y = N−1, the result is exactly R, so the stored words are zero and `overflow` is 1. The bench also covers a short X above which the RAM holds all-ones, odd base addresses, a start pulse in the middle of a run, and a single-word modulus in which the top-word fold-back meets the first word.

// File: rtl/mont_pkg.sv
`timescale 1ns/1ps
package mont_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NLOAD,
        ST_NEWTON,
        ST_XLOAD,
        ST_MUL,
        ST_MULTOP,
        ST_RED,
        ST_REDTOP,
        ST_WB,
        ST_DONE
    } mstate_e;

    localparam int NUM_PTRS = 4;
    localparam int PTR_X    = 0;
    localparam int PTR_Y    = 1;
    localparam int PTR_N    = 2;
    localparam int PTR_R    = 3;

endpackage

// File: rtl/mont_addr.sv
`timescale 1ns/1ps
// Even-aligned base plus word offset.
module mont_addr #(
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        aligned = {base[ADDR_W-1:1], 1'b0};
        off_ext = ADDR_W'(offset);
        addr    = aligned + off_ext;
    end
endmodule

// File: rtl/mont_mac.sv
`timescale 1ns/1ps
// Word multiply-accumulate: acc + a*b + cin, never exceeds 2W bits.
module mont_mac #(
    parameter int W = 32
) (
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   mul_a,
    input  logic [W-1:0]   mul_b,
    input  logic [W-1:0]   cin,
    output logic [2*W-1:0] sum
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod = {{W{1'b0}}, mul_a} * {{W{1'b0}}, mul_b};
        sum  = prod + {{W{1'b0}}, acc} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/mont_newton.sv
`timescale 1ns/1ps
// One Newton step for q with n0*q == -1: each step doubles the valid low bits.
module mont_newton #(
    parameter int W = 32
) (
    input  logic [W-1:0] n0,
    input  logic [W-1:0] q,
    output logic [W-1:0] q_next
);
    logic [W-1:0] corr;

    always_comb begin
        corr   = W'(2) + n0 * q;
        q_next = q * corr;
    end
endmodule

// File: rtl/mont_mul.sv
`timescale 1ns/1ps
module mont_mul
    import mont_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 11,
    parameter int LEN_W     = 8,
    parameter int ACC_W     = 8,
    parameter int MAX_WORDS = 131
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] x_base,
    input  logic [ADDR_W-1:0] y_base,
    input  logic [ADDR_W-1:0] n_base,
    input  logic [ADDR_W-1:0] r_base,
    input  logic [LEN_W-1:0]  x_len,
    input  logic [LEN_W-1:0]  n_len,
    input  logic [ACC_W-1:0]  n_acc,
    output logic              busy,
    output logic              done,
    output logic              overflow,
    output logic [ADDR_W-1:0] ram_a_addr,
    output logic              ram_a_we,
    output logic [WORD_W-1:0] ram_a_wdata,
    input  logic [WORD_W-1:0] ram_a_rdata,
    output logic [ADDR_W-1:0] ram_b_addr,
    input  logic [WORD_W-1:0] ram_b_rdata
);

    localparam int T_WORDS = MAX_WORDS + 2;
    localparam int CNT_W   = $clog2(T_WORDS + 1);

    typedef struct packed {
        mstate_e                        st;
        logic                           ph;
        logic [CNT_W-1:0]               i;
        logic [CNT_W-1:0]               j;
        logic [WORD_W-1:0]              carry;
        logic [WORD_W-1:0]              xw;
        logic [WORD_W-1:0]              mw;
        logic [WORD_W-1:0]              np;
        logic [WORD_W-1:0]              n0;
        logic [LEN_W-1:0]               xl;
        logic [LEN_W-1:0]               nl;
        logic [NUM_PTRS-1:0][ADDR_W-1:0] bases;
        logic                           ovf;
        logic [T_WORDS-1:0][WORD_W-1:0] t;
    } regs_t;

    regs_t r_q, r_d;

    // Shared derived indices
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  s_idx;
    logic [CNT_W-1:0]  s1_idx;
    logic [CNT_W-1:0]  jm1_idx;
    logic [WORD_W-1:0] t_j;
    logic [WORD_W:0]   top_sum;
    logic [WORD_W-1:0] m_next;

    // Address generators, one per operand pointer
    logic [NUM_PTRS-1:0][CNT_W-1:0]  off_v;
    logic [NUM_PTRS-1:0][ADDR_W-1:0] addr_v;

    always_comb begin
        off_v        = '0;
        off_v[PTR_X] = r_q.i;
        off_v[PTR_Y] = r_q.j;
        off_v[PTR_N] = r_q.j;
        off_v[PTR_R] = r_q.j;
    end

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
        mont_addr #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) u_addr (
            .base   (r_q.bases[g]),
            .offset (off_v[g]),
            .addr   (addr_v[g])
        );
    end

    // Word multiply-accumulate shared by both inner passes
    logic               in_red;
    logic [WORD_W-1:0]  mac_a;
    logic [WORD_W-1:0]  mac_b;
    logic [2*WORD_W-1:0] mac_sum;

    always_comb begin
        in_red = (r_q.st == ST_RED);
        mac_a  = in_red ? r_q.mw      : r_q.xw;
        mac_b  = in_red ? ram_b_rdata : ram_a_rdata;
    end

    mont_mac #(.W(WORD_W)) u_mac (
        .acc   (t_j),
        .mul_a (mac_a),
        .mul_b (mac_b),
        .cin   (r_q.carry),
        .sum   (mac_sum)
    );

    logic [WORD_W-1:0] np_next;

    mont_newton #(.W(WORD_W)) u_newton (
        .n0     (r_q.n0),
        .q      (r_q.np),
        .q_next (np_next)
    );

    always_comb begin
        last_idx = CNT_W'(r_q.nl);
        s_idx    = last_idx + CNT_W'(1);
        s1_idx   = last_idx + CNT_W'(2);
        jm1_idx  = r_q.j - CNT_W'(1);
        t_j      = r_q.t[r_q.j];
        top_sum  = {1'b0, r_q.t[s_idx]} + {1'b0, r_q.carry};
        m_next   = r_q.t[0] * r_q.np;
    end

    // Next-state computation
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st           = ST_NLOAD;
                    r_d.ph           = 1'b0;
                    r_d.i            = '0;
                    r_d.j            = '0;
                    r_d.carry        = '0;
                    r_d.t            = '0;
                    r_d.ovf          = 1'b0;
                    r_d.xl           = x_len;
                    r_d.nl           = n_len;
                    r_d.bases[PTR_X] = x_base;
                    r_d.bases[PTR_Y] = y_base;
                    r_d.bases[PTR_N] = n_base;
                    r_d.bases[PTR_R] = r_base;
                    r_d.np           = WORD_W'(n_acc);
                end
            end
            ST_NLOAD: begin
                if (!r_q.ph) begin
                    r_d.ph = 1'b1;
                end else begin
                    r_d.n0 = ram_b_rdata;
                    r_d.ph = 1'b0;
                    r_d.st = ST_NEWTON;
                end
            end
            ST_NEWTON: begin
                r_d.np = np_next;
                r_d.ph = ~r_q.ph;
                if (r_q.ph) begin
                    r_d.st = ST_XLOAD;
                end
            end
            ST_XLOAD: begin
                if (r_q.i > CNT_W'(r_q.xl)) begin
                    r_d.xw    = '0;
                    r_d.st    = ST_MUL;
                    r_d.j     = '0;
                    r_d.ph    = 1'b0;
                    r_d.carry = '0;
                end else if (!r_q.ph) begin
                    r_d.ph = 1'b1;
                end else begin
                    r_d.xw    = ram_a_rdata;
                    r_d.st    = ST_MUL;
                    r_d.j     = '0;
                    r_d.ph    = 1'b0;
                    r_d.carry = '0;
                end
            end
            ST_MUL: begin
                if (!r_q.ph) begin
                    r_d.ph = 1'b1;
                end else begin
                    r_d.ph         = 1'b0;
                    r_d.t[r_q.j]   = mac_sum[WORD_W-1:0];
                    r_d.carry      = mac_sum[2*WORD_W-1:WORD_W];
                    if (r_q.j == last_idx) begin
                        r_d.st = ST_MULTOP;
                    end else begin
                        r_d.j = r_q.j + CNT_W'(1);
                    end
                end
            end
            ST_MULTOP: begin
                r_d.t[s_idx]  = top_sum[WORD_W-1:0];
                r_d.t[s1_idx] = WORD_W'(top_sum[WORD_W]);
                r_d.mw        = m_next;
                r_d.carry     = '0;
                r_d.j         = '0;
                r_d.ph        = 1'b0;
                r_d.st        = ST_RED;
            end
            ST_RED: begin
                if (!r_q.ph) begin
                    r_d.ph = 1'b1;
                end else begin
                    r_d.ph = 1'b0;
                    if (r_q.j != '0) begin
                        r_d.t[jm1_idx] = mac_sum[WORD_W-1:0];
                    end
                    r_d.carry = mac_sum[2*WORD_W-1:WORD_W];
                    if (r_q.j == last_idx) begin
                        r_d.st = ST_REDTOP;
                    end else begin
                        r_d.j = r_q.j + CNT_W'(1);
                    end
                end
            end
            ST_REDTOP: begin
                r_d.t[last_idx] = top_sum[WORD_W-1:0];
                r_d.t[s_idx]    = r_q.t[s1_idx] + WORD_W'(top_sum[WORD_W]);
                r_d.t[s1_idx]   = '0;
                r_d.carry       = '0;
                r_d.ph          = 1'b0;
                if (r_q.i == last_idx) begin
                    r_d.st = ST_WB;
                    r_d.j  = '0;
                end else begin
                    r_d.i  = r_q.i + CNT_W'(1);
                    r_d.st = ST_XLOAD;
                end
            end
            ST_WB: begin
                if (r_q.j == last_idx) begin
                    r_d.st  = ST_DONE;
                    r_d.ovf = (r_q.t[s_idx] != '0);
                end else begin
                    r_d.j = r_q.j + CNT_W'(1);
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Outputs
    always_comb begin
        busy        = (r_q.st != ST_IDLE);
        done        = (r_q.st == ST_DONE);
        overflow    = r_q.ovf;
        ram_a_we    = (r_q.st == ST_WB);
        ram_a_wdata = t_j;
        ram_b_addr  = addr_v[PTR_N];
        if (r_q.st == ST_XLOAD) begin
            ram_a_addr = addr_v[PTR_X];
        end else if (r_q.st == ST_WB) begin
            ram_a_addr = addr_v[PTR_R];
        end else begin
            ram_a_addr = addr_v[PTR_Y];
        end
    end

endmodule

// File: rtl/mont_mul_chk.sv
`timescale 1ns/1ps
module mont_mul_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic overflow,
    input logic ram_a_we
);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ram_a_we));

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_write_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_a_we |-> busy);

    assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_ovf_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !overflow);

    assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(overflow));

endmodule

bind mont_mul mont_mul_chk u_mont_mul_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .overflow (overflow),
    .ram_a_we (ram_a_we)
);

// File: tb/test_mont_mul.sv
`timescale 1ns/1ps
module test_mont_mul;

    localparam int AW = 11;
    localparam int WW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] x_base = '0, y_base = '0, n_base = '0, r_base = '0;
    logic [7:0]    x_len = '0, n_len = '0, n_acc = '0;
    logic          busy, done, overflow;
    logic [AW-1:0] a_addr, b_addr;
    logic          a_we;
    logic [WW-1:0] a_wdata, a_rdata, b_rdata;

    logic [WW-1:0] mem [0:2047];
    logic          tb_we = 1'b0;
    logic [AW-1:0] tb_addr = '0;
    logic [WW-1:0] tb_wdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int cur_rb   = 0;
    int cur_nl   = 0;
    bit prev_we  = 1'b0;

    always #2.5 clk = ~clk;

    mont_mul #(.MAX_WORDS(8)) i_mont_mul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_base(x_base), .y_base(y_base), .n_base(n_base), .r_base(r_base),
        .x_len(x_len), .n_len(n_len), .n_acc(n_acc),
        .busy(busy), .done(done), .overflow(overflow),
        .ram_a_addr(a_addr), .ram_a_we(a_we), .ram_a_wdata(a_wdata), .ram_a_rdata(a_rdata),
        .ram_b_addr(b_addr), .ram_b_rdata(b_rdata)
    );

    // Behavioural dual-port RAM, one-cycle read latency
    always @(posedge clk) begin
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
        if (a_we) mem[a_addr] <= a_wdata;
        else if (tb_we) mem[tb_addr] <= tb_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-clock protocol monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (a_we) begin
                chk(busy, "R2", "write while idle", 64'(busy), 64'd1);
                chk((int'(a_addr) >= cur_rb) && (int'(a_addr) <= cur_rb + cur_nl),
                    "R2", "write address", 64'(a_addr), 64'(cur_rb));
            end
            if (done) chk(prev_we, "R4", "done without preceding write", 64'(prev_we), 64'd1);
            prev_we = a_we;
        end
    end

    function automatic logic [1023:0] ref_np(input logic [1023:0] n, input int s);
        logic [1023:0] mask, inv;
        mask = (1024'd1 << (32 * s)) - 1024'd1;
        inv  = 1024'd1;
        for (int k = 0; k < 11; k++) inv = inv * (1024'd2 - n * inv);
        return (~inv + 1024'd1) & mask;
    endfunction

    function automatic logic [1023:0] ref_mont(input logic [1023:0] x, input logic [1023:0] y,
                                               input logic [1023:0] n, input int s);
        logic [1023:0] mask, np, xy, m;
        mask = (1024'd1 << (32 * s)) - 1024'd1;
        np   = ref_np(n, s);
        xy   = x * y;
        m    = (xy * np) & mask;
        return (xy + m * n) >> (32 * s);
    endfunction

    task automatic put(input int addr, input logic [31:0] data);
        tb_addr  = AW'(addr);
        tb_wdata = data;
        tb_we    = 1'b1;
        @(negedge clk);
        tb_we    = 1'b0;
    endtask

    task automatic run_case(input string tag, input logic [1023:0] n, input logic [1023:0] x,
                            input logic [1023:0] y, input int nl, input int xl,
                            input int xb, input int yb, input int nb, input int rb, input bit poke);
        int xe, ye, ne, re, s, cyc;
        logic [1023:0] xm, expv, mask, got, rr;
        bit exp_ovf;
        xe = xb & ~1; ye = yb & ~1; ne = nb & ~1; re = rb & ~1;
        s  = nl + 1;
        mask = (1024'd1 << (32 * (xl + 1))) - 1024'd1;
        xm   = x & mask;
        for (int k = 0; k < s; k++) put(ne + k, n[32*k +: 32]);
        for (int k = 0; k < s; k++) put(ye + k, y[32*k +: 32]);
        for (int k = 0; k < s; k++) put(xe + k, (k <= xl) ? xm[32*k +: 32] : 32'hFFFF_FFFF);
        put(re - 1, 32'hDEAD_BEEF);
        put(re + s, 32'hDEAD_BEEF);
        expv    = ref_mont(xm, y, n, s);
        rr      = 1024'd1 << (32 * s);
        exp_ovf = (expv >= rr);
        cur_rb  = re; cur_nl = nl;

        x_base = AW'(xb); y_base = AW'(yb); n_base = AW'(nb); r_base = AW'(rb);
        x_len = 8'(xl); n_len = 8'(nl);
        n_acc = ref_np(n, s) & 1024'hFF;   // R8: only the low byte is supplied
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R4", {tag, " busy after start"}, 64'(busy), 64'd1);
        chk(overflow == 1'b0, "R3", {tag, " overflow cleared on start"}, 64'(overflow), 64'd0);

        if (poke) begin
            repeat (10) @(negedge clk);
            n_len = 8'd0; x_base = 11'h7F0; start = 1'b1;   // R5: must be ignored
            @(negedge clk);
            start = 1'b0; n_len = 8'(nl); x_base = AW'(xb);
            chk(busy == 1'b1, "R5", {tag, " still busy after ignored start"}, 64'(busy), 64'd1);
        end

        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R4", {tag, " done reached"}, 64'(done), 64'd1);

        got = '0;
        for (int k = 0; k < s; k++) begin
            got[32*k +: 32] = mem[re + k];
            chk(mem[re + k] == expv[32*k +: 32], "R1",
                $sformatf("%s result word %0d", tag, k), 64'(mem[re + k]), 64'(expv[32*k +: 32]));
        end
        chk(overflow == exp_ovf, "R3", {tag, " overflow flag"}, 64'(overflow), 64'(exp_ovf));
        if (overflow) got = got + rr;
        chk(got < (n << 1), "R1", {tag, " result below 2N"}, got[63:0], n[62:0] * 2);
        chk(mem[re - 1] == 32'hDEAD_BEEF, "R2", {tag, " guard below"}, 64'(mem[re - 1]), 64'hDEAD_BEEF);
        chk(mem[re + s] == 32'hDEAD_BEEF, "R2", {tag, " guard above"}, 64'(mem[re + s]), 64'hDEAD_BEEF);

        @(negedge clk);
        chk(done == 1'b0, "R4", {tag, " done one cycle"}, 64'(done), 64'd0);
        chk(busy == 1'b0, "R4", {tag, " idle after done"}, 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        chk(overflow == exp_ovf, "R3", {tag, " overflow held while idle"}, 64'(overflow), 64'(exp_ovf));
    endtask

    initial begin
        logic [1023:0] n64, n128, x128, y128;
        n64  = 1024'h0E3C1_57A9_0F2D_6B15;
        n128 = 1024'hF1E2D3C4B5A69788_796A5B4C3D2E1F0B;
        x128 = 1024'h8899AABBCCDDEEFF_0011223344556677;
        y128 = 1024'hFEDCBA9876543210_0F1E2D3C4B5A6978;
        for (int k = 0; k < 2048; k++) mem[k] = '0;

        repeat (3) @(negedge clk);
        // R9: reset state
        chk(busy == 1'b0, "R9", "busy in reset", 64'(busy), 64'd0);
        chk(done == 1'b0, "R9", "done in reset", 64'(done), 64'd0);
        chk(overflow == 1'b0, "R9", "overflow in reset", 64'(overflow), 64'd0);
        chk(a_we == 1'b0, "R9", "write enable in reset", 64'(a_we), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R8: 64-bit modulus with padding word
        run_case("c64", n64, 1024'h1234_5678_9ABC_DEF1, 1024'hCAFE_BABE_0DDB_A11F,
                 2, 2, 16'h010, 16'h040, 16'h080, 16'h100, 1'b0);
        // R1 R5: 128-bit modulus, start pulsed mid-run
        run_case("c128", n128, x128, y128, 4, 4, 16'h010, 16'h040, 16'h080, 16'h100, 1'b1);
        // R6: short X with all-ones above its length
        run_case("short_x", n128, 1024'h0BAD_F00D_1234_5678, y128, 4, 1,
                 16'h010, 16'h040, 16'h080, 16'h100, 1'b0);
        // R3: no padding word, exact result R -> overflow set, words zero
        run_case("ovf", 1024'hFFFF_FFFF_FFFF_FFFF, 1024'hFFFF_FFFF_FFFF_FFFE,
                 1024'hFFFF_FFFF_FFFF_FFFE, 1, 1, 16'h010, 16'h040, 16'h080, 16'h100, 1'b0);
        // R3: next run clears the flag
        run_case("c64_again", n64, 1024'h1234_5678_9ABC_DEF1, 1024'hCAFE_BABE_0DDB_A11F,
                 2, 2, 16'h010, 16'h040, 16'h080, 16'h100, 1'b0);
        // R7: odd bases behave as the even address below
        run_case("odd_base", n128, x128, y128, 4, 4, 16'h211, 16'h241, 16'h281, 16'h301, 1'b0);
        // R1: single-word modulus
        run_case("w1", 1024'h3FFF_FFFB, 1024'h1234_5678, 1024'h2ABC_DEF1, 0, 0,
                 16'h010, 16'h040, 16'h080, 16'h100, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule